// File: doc/BRIEF.md
# Disciplined Timestamp Counter

This block keeps a binary timestamp. The count goes up by one on every clock of a fast system clock, about 125 MHz. A once-per-second reference pulse from outside brings it back to zero. When that reference is missing, the surrounding logic can switch the block into local mode. In local mode the counter wraps by itself once it reaches a terminal value, which another block has measured as the number of clock cycles in one second. The count is always in plain binary, so a consumer can use it directly as the sub-second part of a timestamp.

The block has to meet an 8 ns clock period at the full count width. To keep the wide equality test off the path into the counter, the terminal value minus one is kept in its own register. A registered flag records that the count has matched that value. On the next edge the flag clears the counter. A reference pulse wins over the local wrap and also drops any local match that is still pending. A wrap strobe marks the cycle in which the count reads zero after a clear.

Top module: `disc_timestamp`

## Requirements
- R1: While `rst` is high at a rising edge, `count` is 0 and `wrapStrobe` is 0 after that edge.
- R2: At each edge with no clear pending, `count` increases by exactly one.
- R3: An edge at which `refPulse` is 1 leaves `count` at 0, whatever the mode or the count.
- R4: With `localEn` at 1 and a terminal value T (T >= 2), `count` reads T for one cycle and then 0. Starting from a zero, the count sequence is 0, 1, ..., T, 0.
- R5: With `localEn` at 0, `count` passes T and keeps counting upward without any clear.
- R6: A reference pulse at the edge where `count` goes from T-1 to T in local mode gives a single clear. `count` then reads 0, then 1, and `wrapStrobe` is high for that one cycle only.
- R7: `wrapStrobe` is 1 for exactly the cycle in which `count` first reads 0 after a clear, from either cause. It is 0 in the cycles around it.
- R8: `termValue` is sampled on every edge. A new terminal value set one edge or more before a counting run sets the wrap point of that run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, about 125 MHz |
| rst | input | 1 | Synchronous reset, active high |
| refPulse | input | 1 | Single-cycle pulse marking the external once-per-second edge |
| localEn | input | 1 | 1 selects local mode: the counter wraps at the terminal value |
| termValue | input | 28 | Measured clock cycles per second, used as the local terminal value |
| count | output | 28 | Binary timestamp count |
| wrapStrobe | output | 1 | One-cycle pulse in the cycle where the count reads 0 after a clear |

## Verification
A match flag stuck high would hold the count at zero. That shows at the ports one cycle after the first match or right after reset. A flag that is never set lets the count run past T in local mode, visible one cycle after the count reads T. A stale or off-by-one terminal register moves the wrap by one or more counts, so it shows within the first local period. A missing cancel on a reference pulse gives a second zero right after the first one, which the check one cycle after the pulse catches.

// File: rtl/ts_pkg.sv
package ts_pkg;
  // Clear requests from the control module to the datapath
  typedef struct packed {
    logic clrRef;   // external reference clear
    logic clrTerm;  // local terminal-count clear
  } clrStrobes_t;
endpackage

// File: rtl/ts_ctrl.sv
module ts_ctrl
  import ts_pkg::*;
#(
  parameter int WIDTH = 28
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             refPulse,
  input  logic             localEn,
  input  logic [WIDTH-1:0] termValue,
  input  logic [WIDTH-1:0] count,
  output clrStrobes_t      strobes,
  output logic             matchFlag
);
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  logic [WIDTH-1:0] termMinusOne;
  logic             hitNow;

  // Subtract once per edge so the compare sees a register, not an adder
  always_ff @(posedge clk) begin
    if (rst) termMinusOne <= '1;
    else     termMinusOne <= termValue - ONE;
  end

  assign hitNow = (count == termMinusOne);

  // The flag is set in the cycle the count reads T; a reference edge cancels it
  always_ff @(posedge clk) begin
    if (rst) matchFlag <= 1'b0;
    else     matchFlag <= localEn & ~refPulse & hitNow;
  end

  always_comb begin
    strobes.clrRef  = refPulse;
    strobes.clrTerm = matchFlag & localEn & ~refPulse;
  end
endmodule

// File: rtl/ts_datapath.sv
module ts_datapath
  import ts_pkg::*;
#(
  parameter int WIDTH = 28
) (
  input  logic             clk,
  input  logic             rst,
  input  clrStrobes_t      strobes,
  output logic [WIDTH-1:0] count,
  output logic             wrapStrobe
);
  localparam int SUMW = WIDTH + 1;

  logic [SUMW-1:0] incSum;
  logic            clearNow;

  assign incSum   = {1'b0, count} + SUMW'(1);
  assign clearNow = strobes.clrRef | strobes.clrTerm;

  always_ff @(posedge clk) begin
    if (rst) begin
      count      <= '0;
      wrapStrobe <= 1'b0;
    end else begin
      count      <= clearNow ? '0 : incSum[WIDTH-1:0];
      wrapStrobe <= clearNow | incSum[WIDTH];
    end
  end
endmodule

// File: rtl/disc_timestamp.sv
module disc_timestamp
  import ts_pkg::*;
#(
  parameter int WIDTH = 28
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             refPulse,
  input  logic             localEn,
  input  logic [WIDTH-1:0] termValue,
  output logic [WIDTH-1:0] count,
  output logic             wrapStrobe
);
  clrStrobes_t strobes;
  logic        matchFlag;

  ts_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .refPulse  (refPulse),
    .localEn   (localEn),
    .termValue (termValue),
    .count     (count),
    .strobes   (strobes),
    .matchFlag (matchFlag)
  );

  ts_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk        (clk),
    .rst        (rst),
    .strobes    (strobes),
    .count      (count),
    .wrapStrobe (wrapStrobe)
  );
endmodule

// File: rtl/ts_checker.sv
module ts_checker #(
  parameter int WIDTH = 28
) (
  input logic             clk,
  input logic             rst,
  input logic             refPulse,
  input logic             localEn,
  input logic [WIDTH-1:0] count,
  input logic             wrapStrobe,
  input logic             matchFlag
);
  p_reset_zero_r1: assert property (@(posedge clk)
    rst |=> (count == '0) && !wrapStrobe);

  p_increment_r2: assert property (@(posedge clk) disable iff (rst)
    (!refPulse && !(matchFlag && localEn)) |=> count == WIDTH'($past(count) + 1'b1));

  p_ref_clear_r3: assert property (@(posedge clk) disable iff (rst)
    refPulse |=> count == '0);

  p_term_clear_r4: assert property (@(posedge clk) disable iff (rst)
    (localEn && matchFlag && !refPulse) |=> (count == '0) && wrapStrobe);

  p_idle_flag_r5: assert property (@(posedge clk) disable iff (rst)
    !localEn |=> !matchFlag);

  p_cancel_r6: assert property (@(posedge clk) disable iff (rst)
    refPulse |=> !matchFlag);

  p_strobe_zero_r7: assert property (@(posedge clk) disable iff (rst)
    wrapStrobe |-> count == '0);
endmodule

bind disc_timestamp ts_checker #(.WIDTH(WIDTH)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .refPulse   (refPulse),
  .localEn    (localEn),
  .count      (count),
  .wrapStrobe (wrapStrobe),
  .matchFlag  (matchFlag)
);

// File: tb/disc_timestamp_test.sv
`timescale 1ns/1ps
module disc_timestamp_test;
  localparam int W = 28;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         refPulse = 1'b0;
  logic         localEn = 1'b0;
  logic [W-1:0] termValue = W'(20);
  logic [W-1:0] count;
  logic         wrapStrobe;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  disc_timestamp #(.WIDTH(W)) uut (
    .clk(clk), .rst(rst), .refPulse(refPulse), .localEn(localEn),
    .termValue(termValue), .count(count), .wrapStrobe(wrapStrobe)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [W-1:0] actCnt,
                     input logic [W-1:0] expCnt, input logic actStb,
                     input logic expStb);
    checks++;
    if (actCnt !== expCnt || actStb !== expStb) begin
      failures++;
      $display("FAIL %s: count=%0d wrapStrobe=%0b expected count=%0d wrapStrobe=%0b",
               req, actCnt, actStb, expCnt, expStb);
    end
  endtask

  // One reference pulse; afterwards the count reads 0 (sampled at negedge)
  task automatic syncRef();
    refPulse = 1'b1;
    step(1);
    refPulse = 1'b0;
  endtask

  task automatic t_reset();
    step(3);
    chk("R1 reset", count, '0, wrapStrobe, 1'b0);
    rst = 1'b0;
    step(1);
    chk("R2 first count", count, W'(1), wrapStrobe, 1'b0);
    step(5);
    chk("R2 count run", count, W'(6), wrapStrobe, 1'b0);
  endtask

  task automatic t_ref_clear();
    syncRef();
    chk("R3 ref clear", count, '0, wrapStrobe, 1'b1);
    step(1);
    chk("R7 strobe single", count, W'(1), wrapStrobe, 1'b0);
    step(9);
    chk("R2 after ref", count, W'(10), wrapStrobe, 1'b0);
  endtask

  task automatic t_local_wrap();
    termValue = W'(20);
    localEn = 1'b1;
    syncRef();
    step(19);
    chk("R4 before term", count, W'(19), wrapStrobe, 1'b0);
    step(1);
    chk("R4 reads term", count, W'(20), wrapStrobe, 1'b0);
    step(1);
    chk("R4 wraps to zero", count, '0, wrapStrobe, 1'b1);
    step(1);
    chk("R7 strobe drops", count, W'(1), wrapStrobe, 1'b0);
    step(20);
    chk("R4 second period", count, '0, wrapStrobe, 1'b1);
  endtask

  task automatic t_local_off();
    localEn = 1'b0;
    syncRef();
    step(21);
    chk("R5 passes term", count, W'(21), wrapStrobe, 1'b0);
    step(10);
    chk("R5 keeps counting", count, W'(31), wrapStrobe, 1'b0);
  endtask

  task automatic t_cancel();
    localEn = 1'b1;
    termValue = W'(20);
    syncRef();
    step(19);
    chk("R6 setup", count, W'(19), wrapStrobe, 1'b0);
    syncRef();
    chk("R6 ref wins", count, '0, wrapStrobe, 1'b1);
    step(1);
    chk("R6 no second clear", count, W'(1), wrapStrobe, 1'b0);
  endtask

  task automatic t_new_term();
    localEn = 1'b1;
    termValue = W'(8);
    syncRef();
    step(8);
    chk("R8 new term reached", count, W'(8), wrapStrobe, 1'b0);
    step(1);
    chk("R8 new term wrap", count, '0, wrapStrobe, 1'b1);
    termValue = W'(3);
    step(3);
    chk("R8 shorter term reached", count, W'(3), wrapStrobe, 1'b0);
    step(1);
    chk("R8 shorter term wrap", count, '0, wrapStrobe, 1'b1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: run did not complete, expected finish before timeout");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_reset();
    t_ref_clear();
    t_local_wrap();
    t_local_off();
    t_cancel();
    t_new_term();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule